// File: doc/BRIEF.md
# Soft mute and zero detector

This block sits in the per-sample audio path, between the serial input receiver and the converter back end. On every sample strobe it takes one stereo pair of 24-bit two's-complement samples. It returns the pair scaled by a common gain, one clock after the strobe. A mute request moves that gain toward silence in fixed 0.5 dB steps, one step per sample. Once the last step is passed, the output is exactly bipolar zero (code 000000h). Releasing the request walks the gain back to unity in the same steps. A resync input forces the outputs to bipolar zero for every sample it accompanies.

The block also watches the raw input data. It raises a zero flag once both channels have carried zero for a long unbroken run of samples. Any non-zero sample on either channel lowers the flag again.

The gain is held as a step index. Index 0 is unity and index STEPS is silence. The linear multiplier for each index comes from a table computed at elaboration.

Top module: `softmute_zerodet`

## Requirements
- R1: In reset, left_out, right_out, out_valid and zero_flag are all 0, and the gain index is 0 (unity).
- R2: On the clock edge that samples smp_valid=1, the block registers the scaled pair and raises out_valid for one cycle. At index 0, each output equals its input exactly, including 7FFFFFh and 800000h.
- R3: The gain for index k (k < STEPS) is G(k)/65536. Here G(0)=65536 and G(k+1)=floor((G(k)*61870+32768)/65536), which is a 0.5 dB step. Each strobed sample is scaled by the gain of the index held before that strobe.
- R4: While mute_req is 1, each strobe raises the index by one, up to STEPS. The index never moves on a cycle without a strobe. From index STEPS onward, both outputs are exactly 0.
- R5: While mute_req is 0, each strobe lowers the index by one, down to 0. Unity gain is therefore restored STEPS strobes after a full mute.
- R6: A strobe with resync=1 gives 0 on both outputs. It leaves the gain index walking exactly as it would without resync.
- R7: zero_flag rises on the strobe that completes the 1024th consecutive sample in which both left_in and right_in are 0. It stays 1 while further all-zero samples arrive.
- R8: A strobe with a non-zero value on either channel clears zero_flag and restarts the zero run. A run in which only one channel is zero never raises the flag.
- R9: The scaled product is rounded toward zero and saturated to the signed 24-bit range. For example, -3 at index 1 gives -2, and +3 at index 1 gives +2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| left_in | input | 24 | Left sample, two's complement |
| right_in | input | 24 | Right sample, two's complement |
| mute_req | input | 1 | 1 ramps toward silence, 0 ramps toward unity |
| resync | input | 1 | 1 forces bipolar zero on the strobed sample |
| left_out | output | 24 | Scaled left sample |
| right_out | output | 24 | Scaled right sample |
| out_valid | output | 1 | High for one cycle when a scaled pair is presented |
| zero_flag | output | 1 | Both inputs zero for the required run of samples |

## Verification
The gain path is driven with a constant pair of opposite sign through a full mute ramp and a full release ramp. Each step is compared against the recurrence, which separates a wrong step value, an off-by-one in the index and sign handling between channels. Small odd values at index 1 separate rounding toward zero from floor or nearest rounding. Full-scale values at unity expose any saturation or width fault. The zero detector is fed runs of 1023 and 1024 all-zero pairs, a single non-zero right sample and a long run where only one channel is zero. These tell an off-by-one threshold, a missing clear and an OR-instead-of-AND detect apart.

// File: rtl/softmute_zerodet.sv
module softmute_zerodet #(
  parameter int DW       = 24,
  parameter int STEPS    = 64,
  parameter int FRAC     = 16,
  parameter int STEP_MUL = 61870,
  parameter int ZERO_RUN = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] left_in,
  input  logic signed [DW-1:0] right_in,
  input  logic                 mute_req,
  input  logic                 resync,
  output logic signed [DW-1:0] left_out,
  output logic signed [DW-1:0] right_out,
  output logic                 out_valid,
  output logic                 zero_flag
);
  localparam int GW = FRAC + 1;
  localparam int PW = DW + GW;
  localparam int IW = $clog2(STEPS + 1);
  localparam int ZW = $clog2(ZERO_RUN + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(STEPS);
  localparam logic [ZW-1:0] ZLIM = ZW'(ZERO_RUN);
  localparam logic [ZW-1:0] ZPRE = ZW'(ZERO_RUN - 1);
  localparam logic signed [PW:0] RND  = (PW+1)'((longint'(1) << FRAC) - 1);
  localparam logic signed [PW:0] PMAX = (PW+1)'((longint'(1) << (DW-1)) - 1);
  localparam logic signed [PW:0] PMIN = -PMAX - 1;
  localparam logic signed [DW-1:0] OMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] OMIN = {1'b1, {(DW-1){1'b0}}};

  function automatic logic [STEPS*GW-1:0] build_gains();
    logic [STEPS*GW-1:0] tab;
    longint g;
    tab = '0;
    g = longint'(1) << FRAC;
    for (int k = 0; k < STEPS; k++) begin
      tab[k*GW +: GW] = GW'(g);
      g = (g * STEP_MUL + (longint'(1) << (FRAC-1))) >>> FRAC;
    end
    return tab;
  endfunction

  localparam logic [STEPS*GW-1:0] GAINS = build_gains();

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] s,
                                                 input logic [GW-1:0] g);
    logic signed [PW:0] p;
    logic signed [PW:0] q;
    p = (PW+1)'(s) * $signed({1'b0, g});
    if (p < 0) p = p + RND;
    q = p >>> FRAC;
    if (q > PMAX) return OMAX;
    if (q < PMIN) return OMIN;
    return $signed(q[DW-1:0]);
  endfunction

  logic [IW-1:0] idx;
  logic [ZW-1:0] zrun;
  logic [GW-1:0] gain;
  logic          both_zero;

  assign gain      = (idx == LAST_IDX) ? '0 : GAINS[idx*GW +: GW];
  assign both_zero = (left_in == '0) && (right_in == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= '0;
      zrun      <= '0;
      left_out  <= '0;
      right_out <= '0;
      out_valid <= 1'b0;
      zero_flag <= 1'b0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) begin
        left_out  <= resync ? '0 : scale(left_in, gain);
        right_out <= resync ? '0 : scale(right_in, gain);
        if (mute_req && idx != LAST_IDX) idx <= idx + 1'b1;
        else if (!mute_req && idx != '0) idx <= idx - 1'b1;
        if (!both_zero) begin
          zrun      <= '0;
          zero_flag <= 1'b0;
        end else begin
          if (zrun != ZLIM) zrun <= zrun + 1'b1;
          if (zrun >= ZPRE) zero_flag <= 1'b1;
        end
      end
    end
  end

  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX);

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> (idx == $past(idx)) || (idx == $past(idx) + 1'b1) || (idx + 1'b1 == $past(idx)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(idx) && $stable(left_out) && $stable(zero_flag));

  assert_silent_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && idx == LAST_IDX) |=> (left_out == '0) && (right_out == '0));

  assert_resync_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && resync) |=> (left_out == '0) && (right_out == '0));

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !both_zero) |=> !zero_flag);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
endmodule

// File: tb/test_softmute_zerodet.sv
module test_softmute_zerodet;
  localparam int STEPS = 64;
  localparam int ZRUN  = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [23:0] left_in = '0;
  logic signed [23:0] right_in = '0;
  logic mute_req = 1'b0;
  logic resync = 1'b0;
  logic signed [23:0] left_out;
  logic signed [23:0] right_out;
  logic out_valid;
  logic zero_flag;

  int checks = 0;
  int fails = 0;
  longint gtab [STEPS];

  always #10 clk = ~clk;

  softmute_zerodet #(.STEPS(STEPS), .ZERO_RUN(ZRUN)) i_softmute_zerodet (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .left_in(left_in), .right_in(right_in), .mute_req(mute_req), .resync(resync),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid), .zero_flag(zero_flag));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_scaled(input longint v, input int k);
    longint q;
    if (k >= STEPS) return 0;
    q = (v * gtab[k]) / 65536;
    if (q > 8388607) q = 8388607;
    if (q < -8388608) q = -8388608;
    return q;
  endfunction

  task automatic put(input logic signed [23:0] l, input logic signed [23:0] r);
    @(negedge clk);
    left_in = l; right_in = r; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 left_out", left_out, 0);
    chk("R1 right_out", right_out, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 zero_flag", zero_flag, 0);
  endtask

  task automatic test_unity();
    put(24'sh123456, -24'sh00ABCD);
    chk("R2 out_valid", out_valid, 1);
    chk("R1 R2 left unity", left_out, 24'sh123456);
    chk("R2 right unity", right_out, -24'sh00ABCD);
    @(negedge clk);
    chk("R2 out_valid pulse", out_valid, 0);
    put(24'sh7FFFFF, 24'sh800000);
    chk("R2 full-scale pos", left_out, 8388607);
    chk("R2 full-scale neg", right_out, -8388608);
  endtask

  task automatic test_mute_ramp();
    longint v = 1000000;
    mute_req = 1'b1;
    for (int k = 0; k <= STEPS + 2; k++) begin
      put(v, -v);
      chk("R3 R4 ramp down left", left_out, expect_scaled(v, k));
      chk("R3 R4 ramp down right", right_out, expect_scaled(-v, k));
      if (k == 10) begin
        repeat (5) @(negedge clk);
        chk("R4 idle hold", left_out, expect_scaled(v, k));
      end
    end
    chk("R4 silent", left_out, 0);
  endtask

  task automatic test_release_ramp();
    longint v = 2500000;
    mute_req = 1'b0;
    for (int j = 0; j <= STEPS + 2; j++) begin
      int k = (STEPS - j > 0) ? STEPS - j : 0;
      put(-v, v);
      chk("R5 ramp up left", left_out, expect_scaled(-v, k));
      chk("R5 ramp up right", right_out, expect_scaled(v, k));
    end
    chk("R5 unity restored", right_out, v);
  endtask

  task automatic test_resync();
    mute_req = 1'b0;
    resync = 1'b1;
    put(24'sh400000, -24'sh400000);
    chk("R6 resync left zero", left_out, 0);
    chk("R6 resync right zero", right_out, 0);
    mute_req = 1'b1;
    put(24'sh001000, 24'sh001000);
    chk("R6 resync with mute zero", left_out, 0);
    resync = 1'b0;
    mute_req = 1'b0;
    put(24'sh010000, 24'sh010000);
    chk("R6 index walked during resync", left_out, expect_scaled(65536, 1));
    put(24'sh010000, 24'sh010000);
    chk("R6 back to unity", left_out, 65536);
  endtask

  task automatic test_rounding();
    mute_req = 1'b1;
    put(24'sd0, 24'sd0);
    mute_req = 1'b0;
    put(-24'sd3, 24'sd3);
    chk("R9 negative toward zero", left_out, -2);
    chk("R9 positive toward zero", right_out, 2);
    put(24'sd5, -24'sd5);
    chk("R9 unity after", right_out, -5);
  endtask

  task automatic test_zero_detect();
    put(24'sd1, 24'sd1);
    for (int n = 0; n < ZRUN - 1; n++) put(24'sd0, 24'sd0);
    chk("R7 flag low after 1023", zero_flag, 0);
    put(24'sd0, 24'sd0);
    chk("R7 flag high after 1024", zero_flag, 1);
    put(24'sd0, 24'sd0);
    chk("R7 flag held", zero_flag, 1);
    put(24'sd0, 24'sd5);
    chk("R8 cleared by right", zero_flag, 0);
    for (int n = 0; n < ZRUN + 4; n++) put(24'sd0, -24'sd1);
    chk("R8 one channel only", zero_flag, 0);
    for (int n = 0; n < ZRUN; n++) put(24'sd0, 24'sd0);
    chk("R7 restarted run", zero_flag, 1);
    put(-24'sd7, 24'sd0);
    chk("R8 cleared by left", zero_flag, 0);
  endtask

  initial begin
    longint g = 65536;
    for (int k = 0; k < STEPS; k++) begin
      gtab[k] = g;
      g = (g * 61870 + 32768) / 65536;
    end
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_unity();
    test_mute_ramp();
    test_release_ramp();
    test_resync();
    test_rounding();
    test_zero_detect();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule